// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host-side master for a 12-bit serial converter that talks over three wires: an active-low chip select, a serial clock and one serial data line from the converter. A start request in idle drops chip select and starts a divided serial clock taken from the system clock. The converter shifts each bit out on a falling clock edge, so the controller takes each bit on the next rising edge. The first bit that carries information is a null bit, which is thrown away. The twelve data bits that follow, most significant first, are assembled into a signed two's-complement result.

In double-cycle mode chip select stays low after the last data bit. The converter then sends the word again least significant bit first, without repeating bit 0. The controller compares that mirrored copy with the first one and raises an error flag on any difference. In single mode chip select rises right after bit 0 is taken, so no repeat starts. Each finished frame produces a one-cycle done pulse. After each frame chip select stays high for at least one serial clock period.

Top module: `adcr_readout`

## Requirements
- R1: After reset and while no frame runs, cs_n is 1, sclk is 1 and done is 0. Reset clears result and err to 0.
- R2: A start seen in idle drives cs_n to 0 on the next clock. The first falling sclk edge comes HALF_DIV clock cycles after cs_n falls. sclk then toggles every HALF_DIV cycles, so one period is 2*HALF_DIV cycles.
- R3: sdi is taken on rising sclk edges, counted from 1 after cs_n falls. The bits taken on rises 1 and 2 are ignored, so the null bit never reaches the result. Rises 3 to W+2 carry data bits W-1 down to 0.
- R4: In single mode, cs_n returns to 1 on the clock edge that makes rise W+2 (14), so exactly 14 falling and 14 rising sclk edges occur in a frame.
- R5: In double mode (dbl_mode high when the start is accepted), cs_n stays low for rises W+3 to 2W+1 (15 to 25). Those rises carry data bits 1 to W-1 in ascending order. A frame has exactly 25 falling and 25 rising edges.
- R6: err is updated with each done pulse. It is 1 only for a double-mode frame in which some bit k (1..W-1) of the mirrored copy differs from bit k of the first copy. It is 0 for every single-mode frame and for every matching double-mode frame.
- R7: done is a pulse of one clock cycle, given once per frame after cs_n has returned high. result and err change only in the cycle where done is 1 and hold their values otherwise.
- R8: result is a two's-complement number: 0x7FF reads as +2047, 0x800 as -2048 and 0xFFF as -1.
- R9: start is ignored while a frame runs and during the high time after it. Each accepted start gives exactly one frame and one done pulse.
- R10: Between two frames cs_n stays high for at least 2*HALF_DIV clock cycles, even if start is held high.
- R11: The sclk rate CLK_HZ/(2*HALF_DIV) must lie between 0.8 MHz and 4.8 MHz. A parameter set outside that range stops elaboration. The default (100 MHz, 25) gives 2 MHz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request for one frame, acted on only in idle |
| dbl_mode | input | 1 | Selects double-cycle mode when the start is accepted |
| sdi | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| result | output | W | Signed result of the last frame |
| done | output | 1 | One-cycle pulse when a new result is present |
| err | output | 1 | Mismatch between the two copies in double mode |

## Verification
The bench drives a different random value on the null bit in every frame. A design that kept the null bit would have every bit of its result shifted by one position. It compares the number of clock edges in each frame with 14 or 25. An off-by-one end of frame in either mode shows up as a wrong edge count or a wrong top or bottom bit. In double mode it flips one randomly chosen mirrored bit and expects err, then runs a clean frame to confirm that err clears. It holds start high across the gap and also pulses it in the middle of a frame. A design that accepted those requests would give a short chip-select high time or an extra done pulse. The full-scale and minus-one codes are read as signed numbers.

// File: rtl/adcr_pkg.sv
package adcr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_e;

    // Per-cycle event from the sequencer to the word assembler.
    typedef struct packed {
        logic stb;   // a rising sclk edge is made this cycle
        logic fin;   // that edge is the last one of the frame
    } bit_evt_t;

    localparam int unsigned SCLK_MIN_HZ = 800_000;
    localparam int unsigned SCLK_MAX_HZ = 4_800_000;

    function automatic bit sclk_rate_ok(input int unsigned clk_hz, input int unsigned half_div);
        int unsigned f;
        if (half_div == 0) return 1'b0;
        f = clk_hz / (2 * half_div);
        return (f >= SCLK_MIN_HZ) && (f <= SCLK_MAX_HZ);
    endfunction

    // Index of the last rising sclk edge of a frame.
    function automatic int unsigned last_rise(input int unsigned w, input logic dbl);
        return dbl ? (2 * w + 1) : (w + 2);
    endfunction

endpackage

// File: rtl/adcr_sclk_gen.sv
module adcr_sclk_gen #(
    parameter int unsigned HALF_DIV = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic rise_tick
);
    localparam int unsigned CW = $clog2(HALF_DIV + 1);

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick      = run && (cnt == CW'(HALF_DIV - 1));
    assign rise_tick = tick && !sclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            sclk <= 1'b1;
        end else if (tick) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adcr_seq.sv
module adcr_seq
    import adcr_pkg::*;
#(
    parameter int unsigned W        = 12,
    parameter int unsigned HALF_DIV = 25,
    localparam int unsigned IW      = $clog2(2 * W + 3)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          dbl_mode,
    input  logic          rise_tick,
    output logic          cs_n,
    output logic          run,
    output logic          mode_q,
    output logic [IW-1:0] bit_idx,
    output bit_evt_t      evt
);
    localparam int unsigned GAP_LEN = 2 * HALF_DIV;
    localparam int unsigned GW      = $clog2(GAP_LEN + 1);

    seq_state_e    state;
    logic [IW-1:0] rise_cnt;
    logic [GW-1:0] gap_cnt;
    logic [IW-1:0] last_idx;

    assign run      = (state == ST_RUN);
    assign cs_n     = !run;
    assign bit_idx  = rise_cnt + 1'b1;
    assign last_idx = IW'(last_rise(W, mode_q));
    assign evt.stb  = run && rise_tick;
    assign evt.fin  = evt.stb && (bit_idx == last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            rise_cnt <= '0;
            gap_cnt  <= '0;
            mode_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_RUN;
                        mode_q   <= dbl_mode;
                        rise_cnt <= '0;
                    end
                end
                ST_RUN: begin
                    if (evt.stb) rise_cnt <= bit_idx;
                    if (evt.fin) begin
                        state   <= ST_GAP;
                        gap_cnt <= '0;
                    end
                end
                ST_GAP: begin
                    gap_cnt <= gap_cnt + 1'b1;
                    if (gap_cnt == GW'(GAP_LEN - 1)) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adcr_word.sv
module adcr_word
    import adcr_pkg::*;
#(
    parameter int unsigned W  = 12,
    localparam int unsigned IW = $clog2(2 * W + 3)
) (
    input  logic                clk,
    input  logic                rst,
    input  bit_evt_t            evt,
    input  logic [IW-1:0]       bit_idx,
    input  logic                sdi,
    input  logic                mode_q,
    output logic signed [W-1:0] result,
    output logic                done,
    output logic                err
);
    localparam int unsigned FIRST_DATA = 3;
    localparam int unsigned LAST_DATA  = W + 2;

    logic [W-1:0] fwd;     // MSB-first copy
    logic [W-1:1] mir;     // LSB-first repeat, bit 0 is never resent
    logic         fin_q;
    logic         in_fwd;

    assign in_fwd = (bit_idx >= IW'(FIRST_DATA)) && (bit_idx <= IW'(LAST_DATA));

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd <= '0;
            mir <= '0;
        end else if (evt.stb) begin
            if (in_fwd) fwd <= {fwd[W-2:0], sdi};
            for (int j = 1; j < W; j++) begin
                if (bit_idx == IW'(LAST_DATA + j)) mir[j] <= sdi;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fin_q  <= 1'b0;
            done   <= 1'b0;
            err    <= 1'b0;
            result <= '0;
        end else begin
            fin_q <= evt.fin;
            done  <= fin_q;
            if (fin_q) begin
                result <= $signed(fwd);
                err    <= mode_q && (mir != fwd[W-1:1]);
            end
        end
    end
endmodule

// File: rtl/adcr_readout.sv
module adcr_readout
    import adcr_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 100_000_000,
    parameter int unsigned HALF_DIV = 25,
    parameter int unsigned W        = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                dbl_mode,
    input  logic                sdi,
    output logic                cs_n,
    output logic                sclk,
    output logic signed [W-1:0] result,
    output logic                done,
    output logic                err
);
    localparam int unsigned IW = $clog2(2 * W + 3);

    if (!sclk_rate_ok(CLK_HZ, HALF_DIV)) begin : g_bad_rate
        $error("serial clock rate outside 0.8..4.8 MHz for this CLK_HZ/HALF_DIV");
    end

    logic          run;
    logic          rise_tick;
    logic          mode_q;
    logic [IW-1:0] bit_idx;
    bit_evt_t      evt;

    adcr_sclk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk(clk), .rst(rst), .run(run), .sclk(sclk), .rise_tick(rise_tick)
    );

    adcr_seq #(.W(W), .HALF_DIV(HALF_DIV)) u_seq (
        .clk(clk), .rst(rst), .start(start), .dbl_mode(dbl_mode),
        .rise_tick(rise_tick), .cs_n(cs_n), .run(run), .mode_q(mode_q),
        .bit_idx(bit_idx), .evt(evt)
    );

    adcr_word #(.W(W)) u_word (
        .clk(clk), .rst(rst), .evt(evt), .bit_idx(bit_idx), .sdi(sdi),
        .mode_q(mode_q), .result(result), .done(done), .err(err)
    );
endmodule

// File: rtl/adcr_chk.sv
module adcr_chk #(
    parameter int unsigned W        = 12,
    parameter int unsigned HALF_DIV = 25
) (
    input logic         clk,
    input logic         rst,
    input logic         cs_n,
    input logic         sclk,
    input logic         done,
    input logic         err,
    input logic [W-1:0] result,
    input logic         mode_q
);
    localparam int unsigned GAP_LEN = 2 * HALF_DIV;
    localparam int unsigned GW      = $clog2(GAP_LEN + 1);
    localparam int unsigned RW      = $clog2(2 * W + 3);

    logic [GW-1:0] hi_cnt;
    logic [RW-1:0] rc;
    logic          sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= GW'(GAP_LEN);
            rc     <= '0;
            sclk_q <= 1'b1;
        end else begin
            sclk_q <= sclk;
            if (cs_n) begin
                if (hi_cnt < GW'(GAP_LEN)) hi_cnt <= hi_cnt + 1'b1;
                rc <= '0;
            end else begin
                hi_cnt <= '0;
                if (sclk && !sclk_q) rc <= rc + 1'b1;
            end
        end
    end

    // R1: serial clock parked high whenever chip select is inactive
    assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);

    // R7: done never lasts two cycles
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: result holds outside the done cycle
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    // R6: single-mode frames never report a mismatch
    assert_err_single_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !mode_q) |-> !err);

    // R10: minimum chip-select high time before a new frame
    assert_cs_gap_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (hi_cnt >= GW'(GAP_LEN)));

    // R4: rising edges inside one frame stay within the mode's limit
    assert_rise_limit_R4: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> (rc <= (mode_q ? RW'(2 * W + 1) : RW'(W + 2))));
endmodule

bind adcr_readout adcr_chk #(.W(W), .HALF_DIV(HALF_DIV)) u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .done(done),
    .err(err), .result(result), .mode_q(mode_q)
);

// File: tb/sim_adcr_readout.sv
module sim_adcr_readout;
    localparam int W  = 12;
    localparam int HD = 25;
    localparam int CLK_HZ = 100_000_000;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, dbl = 1'b0, sdi = 1'b0;
    logic cs_n, sclk, done, err;
    logic signed [W-1:0] result;

    always #5 clk = ~clk;

    adcr_readout #(.CLK_HZ(CLK_HZ), .HALF_DIV(HD), .W(W)) u0 (
        .clk(clk), .rst(rst), .start(start), .dbl_mode(dbl), .sdi(sdi),
        .cs_n(cs_n), .sclk(sclk), .result(result), .done(done), .err(err)
    );

    int checks = 0, errors = 0;
    int cyc = 0;
    int rises = 0, falls = 0, dones = 0, f_seen = 0;
    int t_cs = 0, t_f1 = 0, t_f2 = 0, hi_len = 0, last_gap = 0;
    logic cs_p = 1'b1, sclk_p = 1'b1;
    logic [W-1:0] cur_word = '0, mir_word = '0;
    logic null_bit = 1'b0;
    int drv_f = 0;
    bit finished = 0;

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor sampled away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (cs_p && !cs_n) begin
            t_cs = cyc; f_seen = 0; rises = 0; falls = 0; last_gap = hi_len;
        end
        if (!cs_p && sclk_p && !sclk) begin
            falls++;
            if (f_seen == 0) t_f1 = cyc;
            else if (f_seen == 1) t_f2 = cyc;
            f_seen++;
        end
        if (!cs_p && !sclk_p && sclk) rises++;
        if (cs_n) hi_len++; else hi_len = 0;
        if (done) dones++;
        cs_p = cs_n;
        sclk_p = sclk;
    end

    // Converter model: new bit after every falling sclk edge
    always @(negedge cs_n) drv_f = 0;
    always @(negedge sclk) begin
        if (!cs_n) begin
            drv_f++;
            if (drv_f == 2) sdi <= null_bit;
            else if (drv_f >= 3 && drv_f <= W + 2) sdi <= cur_word[W + 2 - drv_f];
            else if (drv_f >= W + 3 && drv_f <= 2 * W + 1) sdi <= mir_word[drv_f - W - 2];
            else sdi <= 1'($urandom);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 190000 && !finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            summary();
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    bit first_frame = 1;

    task automatic run_frame(input logic [W-1:0] w, input bit d, input bit corrupt, input int busy_at);
        int pos, n, d0, exp_edges;
        cur_word = w;
        mir_word = w;
        if (corrupt) begin
            pos = 1 + int'($urandom % (W - 1));
            mir_word[pos] = ~mir_word[pos];
        end
        null_bit = 1'($urandom);
        d0 = dones;
        dbl = d;
        start = 1'b1;
        n = 0;
        while (cs_n && n < 5000) begin step(); n++; end
        start = 1'b0;
        chk(!cs_n, "R2", "cs_n low after start", cs_n, 0);
        if (!first_frame) chk(last_gap >= 2 * HD, "R10", "cs_n high time", last_gap, 2 * HD);
        if (busy_at > 0) begin
            repeat (busy_at) step();
            start = 1'b1;
            step();
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 5000) begin step(); n++; end
        exp_edges = d ? 2 * W + 1 : W + 2;
        chk(done == 1'b1, "R7", "done seen", done, 1);
        chk(result == w, d ? "R5" : "R3", "result word", int'(unsigned'(result)), int'(w));
        chk(err == (d && corrupt), "R6", "err flag", err, int'(d && corrupt));
        chk(rises == exp_edges, d ? "R5" : "R4", "rising edges", rises, exp_edges);
        chk(falls == exp_edges, d ? "R5" : "R4", "falling edges", falls, exp_edges);
        if (first_frame) begin
            chk(t_f1 - t_cs == HD, "R2", "cs to first fall", t_f1 - t_cs, HD);
            chk(t_f2 - t_f1 == 2 * HD, "R2", "sclk period", t_f2 - t_f1, 2 * HD);
            chk(CLK_HZ / (t_f2 - t_f1) >= 800_000 && CLK_HZ / (t_f2 - t_f1) <= 4_800_000,
                "R11", "sclk rate", CLK_HZ / (t_f2 - t_f1), CLK_HZ / (2 * HD));
        end
        step();
        chk(done == 1'b0, "R7", "done one cycle", done, 0);
        chk(cs_n == 1'b1, "R1", "cs_n high after frame", cs_n, 1);
        chk(dones == d0 + 1, busy_at > 0 ? "R9" : "R7", "done pulses per frame", dones - d0, 1);
        first_frame = 0;
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED_0C1A);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        step();
        chk(cs_n == 1'b1 && sclk == 1'b1, "R1", "idle lines after reset", {cs_n, sclk}, 3);
        chk(done == 1'b0 && err == 1'b0, "R1", "done/err after reset", {done, err}, 0);
        chk(result == 0, "R1", "result after reset", int'(result), 0);
        repeat (100) step();
        chk(hi_len >= 100 && sclk == 1'b1, "R1", "idle without start", hi_len, 100);

        // Directed corner cases
        run_frame(12'h7FF, 1'b0, 1'b0, 0);
        chk(result == 12'sd2047, "R8", "positive full scale", int'(result), 2047);
        run_frame(12'h800, 1'b1, 1'b0, 0);
        chk(result == -12'sd2048, "R8", "negative full scale", int'(result), -2048);
        run_frame(12'hFFF, 1'b0, 1'b0, 0);
        chk(result == -12'sd1, "R8", "one below zero", int'(result), -1);
        run_frame(12'h000, 1'b1, 1'b0, 0);
        run_frame(12'h555, 1'b1, 1'b1, 0);
        run_frame(12'h123, 1'b0, 1'b0, 0);
        run_frame(12'hA5A, 1'b1, 1'b1, 0);
        run_frame(12'hA5A, 1'b1, 1'b0, 0);
        run_frame(12'h3C3, 1'b0, 1'b0, 300);
        run_frame(12'hC3C, 1'b1, 1'b0, 900);

        // Random frames
        for (int i = 0; i < 30; i++) begin
            logic [W-1:0] w;
            bit d, c;
            int b;
            w = W'($urandom);
            d = 1'($urandom);
            c = d && ($urandom % 3 == 0);
            b = ($urandom % 4 == 0) ? 50 + int'($urandom % 500) : 0;
            run_frame(w, d, c, b);
        end

        finished = 1;
        summary();
    end
endmodule